// File: doc/BRIEF.md
# Asymmetric Complementary Dead-Time Generator

This block turns a single PWM reference into a complementary pair of drive signals. Around every reference transition, both drives are first held low. The drive that is about to turn on is released only after a programmed gap. This gap keeps the two switches of a half bridge from conducting at the same time.

The gap after a rising reference edge and the gap after a falling reference edge can be set separately. Each gap is given as an 8-bit code with four ranges. The top bits of the code choose the step size, which is 1, 2, 8 or 16 clock cycles, and the low bits give the count. A write strobe loads the configuration. A lock level, once set above zero, freezes the falling-edge code and the asymmetric-enable bit until the next reset.

Top module: `deadtime_pair`

## Requirements
- R1: After reset both drives are low, and the lock level, both codes and the asymmetric-enable bit are 0. With the reset configuration, a reference edge therefore switches its drive with no gap.
- R2: On a rising reference edge, `drv_lo` goes low at the first clock edge that samples the new level. `drv_hi` goes high exactly the rising gap later, counted in clock cycles from that edge.
- R3: On a falling reference edge, `drv_hi` goes low at the first clock edge that samples the new level. `drv_lo` goes high exactly the falling gap later.
- R4: With `asym_wr` stored as 0, the falling gap is decoded from the rising code.
- R5: With `asym_wr` stored as 1, the falling gap is decoded from the falling code.
- R6: If code bit 7 is 0, the gap is code[6:0] cycles.
- R7: If code bits [7:6] are 2'b10, the gap is (64 + code[5:0]) × 2 cycles.
- R8: If code bits [7:5] are 3'b110, the gap is (32 + code[4:0]) × 8 cycles.
- R9: If code bits [7:5] are 3'b111, the gap is (32 + code[4:0]) × 16 cycles.
- R10: A write with `cfg_wr` high always loads the rising code. It loads the falling code, the asymmetric bit and the lock level only while the stored lock level is 0. Any nonzero lock level (1, 2 or 3) holds those three fields until reset.
- R11: If the reference changes again before a gap has run out, the drive that was waiting never goes high. The gap count restarts for the new edge.
- R12: A code that decodes to a gap of 0 switches the waiting drive on the same clock edge that samples the reference change.
- R13: `drv_hi` and `drv_lo` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one gap unit |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_ref | input | 1 | PWM reference to be split |
| cfg_wr | input | 1 | Configuration write strobe |
| rise_code_wr | input | 8 | Rising-edge gap code to write |
| fall_code_wr | input | 8 | Falling-edge gap code to write |
| asym_wr | input | 1 | Asymmetric-enable value to write |
| lock_wr | input | 2 | Lock level value to write |
| drv_hi | output | 1 | Main drive, follows the reference |
| drv_lo | output | 1 | Complementary drive |

## Verification
Take edge k as the first rising clock edge that samples a new reference level. The drive that turns off is low after edge k. The drive that turns on is high after edge k+D, where D is the decoded gap, so D = 0 switches it at edge k itself. A configuration write is visible from the edge that samples the strobe onward. The driver changes the reference at falling clock edges and pushes one expected drive pair per cycle. The expected pair for cycle i after edge k is "on" exactly when i ≥ D. The monitor compares each pushed pair one time unit after the following rising edge, so every comparison falls after the only register stage between the reference and the drives.

// File: rtl/deadtime_pkg.sv
package deadtime_pkg;
    localparam int CODE_W = 8;
    // largest gap is (32+31)*16 = 1008 cycles
    localparam int DLY_W  = 10;
    localparam int N_EDGE = 2;   // index 0: rising code, 1: falling code

    typedef struct packed {
        logic [CODE_W-1:0] rise_code;
        logic [CODE_W-1:0] fall_code;
        logic              asym;
        logic [1:0]        lock;
    } cfg_t;

    typedef struct packed {
        logic             ref_s;
        logic             hi;
        logic             lo;
        logic             tgt_hi;
        logic [DLY_W-1:0] cnt;
    } gap_st_t;
endpackage

// File: rtl/deadtime_cfg.sv
module deadtime_cfg
    import deadtime_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [CODE_W-1:0] rise_in,
    input  logic [CODE_W-1:0] fall_in,
    input  logic              asym_in,
    input  logic [1:0]        lock_in,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr) begin
            cfg_d.rise_code = rise_in;
            // protected fields (including the level itself) only while unlocked
            if (cfg_q.lock == 2'd0) begin
                cfg_d.fall_code = fall_in;
                cfg_d.asym      = asym_in;
                cfg_d.lock      = lock_in;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/deadtime_decode.sv
module deadtime_decode
    import deadtime_pkg::*;
(
    input  logic [CODE_W-1:0] code,
    output logic [DLY_W-1:0]  cycles
);
    always_comb begin
        unique casez (code[7:5])
            3'b0??:  cycles = {{(DLY_W-7){1'b0}}, code[6:0]};
            3'b10?:  cycles = (DLY_W'(64) + DLY_W'(code[5:0])) << 1;
            3'b110:  cycles = (DLY_W'(32) + DLY_W'(code[4:0])) << 3;
            default: cycles = (DLY_W'(32) + DLY_W'(code[4:0])) << 4;
        endcase
    end
endmodule

// File: rtl/deadtime_timer.sv
module deadtime_timer
    import deadtime_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic [DLY_W-1:0] rise_gap,
    input  logic [DLY_W-1:0] fall_gap,
    output logic             hi,
    output logic             lo
);
    gap_st_t st_d, st_q;
    logic    up_edge, dn_edge;

    assign up_edge = ref_in & ~st_q.ref_s;
    assign dn_edge = ~ref_in & st_q.ref_s;

    always_comb begin
        st_d       = st_q;
        st_d.ref_s = ref_in;
        if (up_edge) begin
            st_d.lo     = 1'b0;
            st_d.tgt_hi = 1'b1;
            st_d.hi     = (rise_gap == '0);
            st_d.cnt    = rise_gap;
        end else if (dn_edge) begin
            st_d.hi     = 1'b0;
            st_d.tgt_hi = 1'b0;
            st_d.lo     = (fall_gap == '0);
            st_d.cnt    = fall_gap;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
            if (st_q.cnt == DLY_W'(1)) begin
                if (st_q.tgt_hi) st_d.hi = 1'b1;
                else             st_d.lo = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign hi = st_q.hi;
    assign lo = st_q.lo;
endmodule

// File: rtl/deadtime_pair.sv
module deadtime_pair
    import deadtime_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pwm_ref,
    input  logic              cfg_wr,
    input  logic [CODE_W-1:0] rise_code_wr,
    input  logic [CODE_W-1:0] fall_code_wr,
    input  logic              asym_wr,
    input  logic [1:0]        lock_wr,
    output logic              drv_hi,
    output logic              drv_lo
);
    cfg_t              cfg;
    logic [1:0]        lock_lvl;
    logic              asym_cfg;
    logic [CODE_W-1:0] fall_cfg;
    logic [N_EDGE-1:0][CODE_W-1:0] codes;
    logic [N_EDGE-1:0][DLY_W-1:0]  gaps;
    logic [DLY_W-1:0]  fall_gap_sel;

    deadtime_cfg u_cfg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr      (cfg_wr),
        .rise_in (rise_code_wr),
        .fall_in (fall_code_wr),
        .asym_in (asym_wr),
        .lock_in (lock_wr),
        .cfg     (cfg)
    );

    assign lock_lvl = cfg.lock;
    assign asym_cfg = cfg.asym;
    assign fall_cfg = cfg.fall_code;
    assign codes[0] = cfg.rise_code;
    assign codes[1] = cfg.fall_code;

    for (genvar g = 0; g < N_EDGE; g++) begin : g_dec
        deadtime_decode u_dec (
            .code   (codes[g]),
            .cycles (gaps[g])
        );
    end

    assign fall_gap_sel = asym_cfg ? gaps[1] : gaps[0];

    deadtime_timer u_tmr (
        .clk      (clk),
        .rst_n    (rst_n),
        .ref_in   (pwm_ref),
        .rise_gap (gaps[0]),
        .fall_gap (fall_gap_sel),
        .hi       (drv_hi),
        .lo       (drv_lo)
    );
endmodule

// File: rtl/deadtime_checker.sv
module deadtime_checker (
    input logic              clk,
    input logic              rst_n,
    input logic              pwm_ref,
    input logic              drv_hi,
    input logic              drv_lo,
    input logic [1:0]        lock_lvl,
    input logic              asym_cfg,
    input logic [7:0]        fall_cfg
);
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
        !(drv_hi && drv_lo)); // R13

    AST_RISE_LO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pwm_ref) |=> !drv_lo); // R2

    AST_FALL_HI_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pwm_ref) |=> !drv_hi); // R3

    AST_HI_NEEDS_REF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(drv_hi) |-> $past(pwm_ref)); // R11

    AST_LOCK_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        (lock_lvl != 2'd0) |=> ($stable(asym_cfg) && $stable(fall_cfg)
                                && lock_lvl != 2'd0)); // R10
endmodule

bind deadtime_pair deadtime_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwm_ref  (pwm_ref),
    .drv_hi   (drv_hi),
    .drv_lo   (drv_lo),
    .lock_lvl (lock_lvl),
    .asym_cfg (asym_cfg),
    .fall_cfg (fall_cfg)
);

// File: tb/sim_deadtime_pair.sv
`timescale 1ns/1ps
module sim_deadtime_pair;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pwm_ref = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [7:0] rise_code_wr = '0;
    logic [7:0] fall_code_wr = '0;
    logic       asym_wr = 1'b0;
    logic [1:0] lock_wr = '0;
    logic       drv_hi, drv_lo;

    int n_chk = 0;
    int n_bad = 0;
    logic [1:0] exp_q[$];
    string      tag_q[$];
    bit         done = 1'b0;

    always #2.5 clk = ~clk;   // 200 MHz

    deadtime_pair u0 (
        .clk(clk), .rst_n(rst_n), .pwm_ref(pwm_ref), .cfg_wr(cfg_wr),
        .rise_code_wr(rise_code_wr), .fall_code_wr(fall_code_wr),
        .asym_wr(asym_wr), .lock_wr(lock_wr), .drv_hi(drv_hi), .drv_lo(drv_lo)
    );

    function automatic int gap_of(input logic [7:0] c);
        if (!c[7])          return int'(c[6:0]);            // R6
        else if (!c[6])     return (64 + int'(c[5:0])) * 2; // R7
        else if (!c[5])     return (32 + int'(c[4:0])) * 8; // R8
        else                return (32 + int'(c[4:0])) * 16; // R9
    endfunction

    task automatic check(input string tag, input logic [1:0] got, input logic [1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: {hi,lo} got %b expected %b at %0t", tag, got, exp, $time);
        end
    endtask

    // driver: hold reference r for n cycles; drive turning on waits dly cycles
    task automatic drive(input logic r, input int n, input int dly, input string tag);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pwm_ref = r;
            if (r) exp_q.push_back({(i >= dly), 1'b0});
            else   exp_q.push_back({1'b0, (i >= dly)});
            tag_q.push_back(tag);
        end
    endtask

    task automatic cfg(input logic [7:0] rc, input logic [7:0] fc,
                       input logic a, input logic [1:0] lk);
        @(negedge clk);
        cfg_wr = 1'b1; rise_code_wr = rc; fall_code_wr = fc; asym_wr = a; lock_wr = lk;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // monitor: compare one time unit after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (exp_q.size() > 0) begin
                logic [1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(t, {drv_hi, drv_lo}, e);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset", {drv_hi, drv_lo}, 2'b00);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 idle after reset", {drv_hi, drv_lo}, 2'b00);
        // reset codes are zero: no gap
        drive(1'b1, 3, 0, "R1 R12 rise zero gap");
        drive(1'b0, 3, 0, "R1 R12 fall zero gap");
        // symmetric: fall uses rising code
        cfg(8'd5, 8'h81, 1'b0, 2'd0);
        drive(1'b1, 8, 5, "R2 R6 rise gap 5");
        drive(1'b0, 8, 5, "R3 R4 fall from rise code");
        // asymmetric with linear and x2 ranges
        cfg(8'h7F, 8'h81, 1'b1, 2'd0);
        drive(1'b1, 130, gap_of(8'h7F), "R6 rise gap 127");
        drive(1'b0, 133, gap_of(8'h81), "R5 R7 fall gap 130");
        // x8 and x16 ranges
        cfg(8'hC2, 8'hE3, 1'b1, 2'd0);
        drive(1'b1, 275, gap_of(8'hC2), "R8 rise gap 272");
        drive(1'b0, 563, gap_of(8'hE3), "R9 fall gap 560");
        // asymmetric zero falling gap
        cfg(8'd4, 8'd0, 1'b1, 2'd0);
        drive(1'b1, 6, 4, "R5 rise gap 4");
        drive(1'b0, 3, 0, "R12 fall zero gap");
        // retrigger before gaps expire
        cfg(8'd20, 8'd30, 1'b1, 2'd0);
        drive(1'b1, 10, 20, "R11 short high");
        drive(1'b0, 40, 30, "R11 restart fall");
        drive(1'b1, 25, 20, "R2 full rise");
        drive(1'b0, 5, 30, "R11 short low");
        drive(1'b1, 25, 20, "R11 restart rise");
        drive(1'b0, 35, 30, "R3 full fall");
        // lock: this write lands (lock was 0), later ones keep fall/asym/lock
        cfg(8'hFF, 8'd10, 1'b1, 2'd2);
        drive(1'b1, 1011, gap_of(8'hFF), "R9 rise gap 1008");
        drive(1'b0, 13, 10, "R10 fall code taken");
        cfg(8'd3, 8'h40, 1'b0, 2'd0);
        drive(1'b1, 6, 3, "R10 rise code still writable");
        drive(1'b0, 13, 10, "R10 fall code and asym held");
        cfg(8'd3, 8'd7, 1'b1, 2'd0);
        drive(1'b1, 6, 3, "R10 rise");
        drive(1'b0, 13, 10, "R10 lock level held");
        repeat (3) @(negedge clk);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: run did not finish, got timeout expected completion");
            end
        join_any
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule